// File: doc/BRIEF.md
# Counter Ramp Conversion Controller

This block sequences a counter-type analog-to-digital conversion. It drives a binary code to an external DAC, whose output goes to one input of an analog comparator; the analog input goes to the other. A one-cycle `start` pulse clears the code to zero. From then on, the code climbs by one step at a time for as long as the comparator reports that the input is still above the DAC output. The first low comparator reading freezes the code, and that frozen code is the conversion result.

A small input therefore converts in a few steps, and a large one needs many steps. Each step lasts `SETTLE + 1` clocks. During the first `SETTLE` clocks the code is held while the DAC and comparator settle. In the last clock the comparator is read. If the code reaches all ones and the comparator is still high, the conversion ends and a full-scale flag is raised. Each new conversion needs another `start` pulse. A `start` that arrives during a conversion restarts it from zero.

Top module: `ramp_conv_ctrl`

## Requirements
- R1: While `rstN` is low, and after its release with no `start`, `dacCode`, `result`, `done`, `fullScale` and `busy` are all 0.
- R2: In the cycle after `start` is sampled high, `dacCode` is 0, `result` is 0, `fullScale` is 0, `done` is 0 and `busy` is 1.
- R3: While `busy`, `dacCode` holds for `SETTLE` clocks and then rises by exactly one when `cmpHigh` (1 = analog input above DAC output) is sampled high on the compare clock. A step is therefore `SETTLE + 1` clocks long.
- R4: The first compare clock with `cmpHigh` low ends the conversion. `dacCode` stops, and `result` takes the value that `dacCode` had on that compare clock.
- R5: `done` is high for exactly one cycle. For a final code k it is first seen (k+1)·(SETTLE+1) clocks after the `start` edge, and `busy` is low while `done` is high.
- R6: After a conversion ends, `dacCode` and `result` hold, whatever `cmpHigh` does, until the next `start`.
- R7: If `cmpHigh` is still high on the compare clock with `dacCode` at all ones, the conversion ends with `result` all ones, `fullScale` 1 and `done` pulsed. When it ends on a low reading, `fullScale` is 0.
- R8: A `start` during a conversion abandons it, and the code restarts from 0 with the same timing as R5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-cycle pulse that clears the code and begins a conversion |
| cmpHigh | input | 1 | Comparator output, 1 while the analog input exceeds the DAC output |
| dacCode | output | WIDTH | Code driven to the DAC |
| result | output | WIDTH | Conversion result, held until the next start |
| done | output | 1 | One-cycle pulse when `result` becomes valid |
| fullScale | output | 1 | Set when the conversion ran to all ones without a low comparator reading |
| busy | output | 1 | High while a conversion is counting |

## Verification
The bench models the DAC and comparator ideally as `cmpHigh = vin > dacCode`. For any input `vin`, the final code is therefore min(vin, 2^WIDTH−1). The `done` pulse is due (k+1)·(SETTLE+1) clocks after the `start` edge. The bench changes inputs on falling edges and counts falling edges from the `start` edge, so the cycle in which `done` appears is compared exactly, not merely waited for. During the conversion, every sampled `dacCode` is compared with floor(elapsed/(SETTLE+1)). The held values are read again several cycles after the comparator input has been disturbed.

// File: rtl/ramp_conv_pkg.sv
package ramp_conv_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WAIT = 2'd1,
    ST_CMP  = 2'd2,
    ST_HOLD = 2'd3
  } conv_state_t;

  typedef struct packed {
    logic clearAll;
    logic incr;
    logic capture;
    logic markFull;
  } conv_strobe_t;

endpackage

// File: rtl/ramp_ctrl.sv
module ramp_ctrl
  import ramp_conv_pkg::*;
#(
  parameter int SETTLE = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         cmpHigh,
  input  logic         atMax,
  output conv_strobe_t strobe,
  output logic         busy
);
  localparam int WW = (SETTLE < 1) ? 1 : $clog2(SETTLE + 1);
  localparam logic [WW-1:0] WAIT_LOAD = WW'(SETTLE);
  localparam conv_state_t STEP_STATE = (SETTLE == 0) ? ST_CMP : ST_WAIT;

  conv_state_t stateQ, stateD;
  logic [WW-1:0] waitQ, waitD;

  always_comb begin
    stateD = stateQ;
    waitD  = waitQ;
    strobe = '0;
    if (start) begin
      strobe.clearAll = 1'b1;
      waitD  = WAIT_LOAD;
      stateD = STEP_STATE;
    end else begin
      case (stateQ)
        ST_WAIT: begin
          if (waitQ <= WW'(1)) stateD = ST_CMP;
          else                 waitD  = waitQ - WW'(1);
        end
        ST_CMP: begin
          if (cmpHigh && !atMax) begin
            strobe.incr = 1'b1;
            waitD  = WAIT_LOAD;
            stateD = STEP_STATE;
          end else begin
            strobe.capture  = 1'b1;
            strobe.markFull = cmpHigh;
            stateD = ST_HOLD;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      waitQ  <= '0;
    end else begin
      stateQ <= stateD;
      waitQ  <= waitD;
    end
  end

  assign busy = (stateQ == ST_WAIT) || (stateQ == ST_CMP);
endmodule

// File: rtl/ramp_datapath.sv
module ramp_datapath
  import ramp_conv_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  conv_strobe_t     strobe,
  output logic [WIDTH-1:0] count,
  output logic [WIDTH-1:0] result,
  output logic             done,
  output logic             fullScale,
  output logic             atMax
);
  logic [WIDTH-1:0] countQ, resultQ;
  logic doneQ, fullQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      countQ  <= '0;
      resultQ <= '0;
      doneQ   <= 1'b0;
      fullQ   <= 1'b0;
    end else if (strobe.clearAll) begin
      countQ  <= '0;
      resultQ <= '0;
      doneQ   <= 1'b0;
      fullQ   <= 1'b0;
    end else begin
      doneQ <= strobe.capture;
      if (strobe.incr) countQ <= countQ + WIDTH'(1);
      if (strobe.capture) begin
        resultQ <= countQ;
        fullQ   <= strobe.markFull;
      end
    end
  end

  assign count     = countQ;
  assign result    = resultQ;
  assign done      = doneQ;
  assign fullScale = fullQ;
  assign atMax     = &countQ;
endmodule

// File: rtl/ramp_conv_ctrl.sv
module ramp_conv_ctrl
  import ramp_conv_pkg::*;
#(
  parameter int WIDTH  = 8,
  parameter int SETTLE = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic             cmpHigh,
  output logic [WIDTH-1:0] dacCode,
  output logic [WIDTH-1:0] result,
  output logic             done,
  output logic             fullScale,
  output logic             busy
);
  conv_strobe_t strobe;
  logic atMax;

  ramp_ctrl #(.SETTLE(SETTLE)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .cmpHigh(cmpHigh),
    .atMax(atMax), .strobe(strobe), .busy(busy)
  );

  ramp_datapath #(.WIDTH(WIDTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .count(dacCode),
    .result(result), .done(done), .fullScale(fullScale), .atMax(atMax)
  );
endmodule

// File: rtl/ramp_conv_chk.sv
module ramp_conv_chk #(
  parameter int WIDTH = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic             start,
  input logic [WIDTH-1:0] dacCode,
  input logic [WIDTH-1:0] result,
  input logic             done,
  input logic             fullScale,
  input logic             busy
);
  p_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    start |=> (dacCode == '0 && result == '0 && !done && !fullScale && busy));

  p_step_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!start && busy) |=> (dacCode == $past(dacCode) || dacCode == $past(dacCode) + WIDTH'(1)));

  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  p_done_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!start && !busy) |=> ($stable(dacCode) && $stable(result)));

  p_full_r7: assert property (@(posedge clk) disable iff (!rstN)
    fullScale |-> (result == '1));
endmodule

bind ramp_conv_ctrl ramp_conv_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rstN(rstN), .start(start), .dacCode(dacCode), .result(result),
  .done(done), .fullScale(fullScale), .busy(busy)
);

// File: tb/ramp_conv_ctrl_tb.sv
module ramp_conv_ctrl_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WIDTH  = 8;
  localparam int SETTLE = 2;
  localparam int MAXC   = (1 << WIDTH) - 1;
  localparam int STEP   = SETTLE + 1;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [WIDTH:0] vin = '0;
  logic cmpHigh;
  logic [WIDTH-1:0] dacCode, result;
  logic done, fullScale, busy;
  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  assign cmpHigh = (vin > {1'b0, dacCode});

  ramp_conv_ctrl #(.WIDTH(WIDTH), .SETTLE(SETTLE)) u_dut (
    .clk(clk), .rstN(rstN), .start(start), .cmpHigh(cmpHigh),
    .dacCode(dacCode), .result(result), .done(done),
    .fullScale(fullScale), .busy(busy)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int finalCode(input int v);
    return (v > MAXC) ? MAXC : v;
  endfunction

  function automatic int doneDelay(input int v);
    return (finalCode(v) + 1) * STEP;
  endfunction

  task automatic runConv(input int v, input int restartAfter);
    int n;
    int badSteps;
    int k;
    if (restartAfter > 0) begin
      vin = (WIDTH + 1)'(200);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (restartAfter) @(negedge clk);
    end
    vin = (WIDTH + 1)'(v);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    // R2 / R8: cleared one cycle after the start edge
    check(dacCode == 0 && result == 0 && !fullScale && !done && busy,
          (restartAfter > 0) ? "R8 restart clears" : "R2 clear after start",
          int'(dacCode), 0);
    n = 1;
    badSteps = 0;
    while (!done && n < 4 * STEP * (MAXC + 2)) begin
      if (busy && int'(dacCode) != (n - 1) / STEP) badSteps++;
      @(negedge clk);
      n++;
    end
    k = finalCode(v);
    check(badSteps == 0, "R3 step timing", badSteps, 0);
    check(done && n == doneDelay(v) + 1, "R5 done latency", n - 1, doneDelay(v));
    check(int'(result) == k && int'(dacCode) == k, "R4 result", int'(result), k);
    check(fullScale == (v > MAXC), "R7 full-scale flag", int'(fullScale), int'(v > MAXC));
    check(!busy, "R5 not busy with done", int'(busy), 0);
    @(negedge clk);
    check(!done, "R5 done single cycle", int'(done), 0);
    vin = (WIDTH + 1)'($urandom % (MAXC + 40));
    repeat (5) @(negedge clk);
    check(int'(result) == k && int'(dacCode) == k && !done,
          "R6 hold after done", int'(result), k);
  endtask

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(dacCode == 0 && result == 0 && !done && !fullScale && !busy,
          "R1 reset state", int'(dacCode), 0);
    rstN = 1'b1;
    vin = (WIDTH + 1)'(50);
    repeat (4) @(negedge clk);
    check(dacCode == 0 && result == 0 && !done && !busy,
          "R1 idle without start", int'(dacCode), 0);
    runConv(0, 0);
    runConv(1, 0);
    runConv(MAXC - 1, 0);
    runConv(MAXC, 0);
    runConv(MAXC + 1, 0);
    runConv(MAXC + 30, 0);
    runConv(17, 11);
    runConv(90, 1);
    for (int i = 0; i < 16; i++) runConv(int'($urandom % (MAXC + 40)), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule